// File: doc/BRIEF.md
# Far-End Failure Alarm Persistence Detector

This block sits behind the overhead extraction stage of an E3 receive framer. Once per received frame the extractor presents the remote-alarm bit together with a one-cycle frame strobe. The detector filters that bit with a persistence rule. It raises a far-end failure condition only after the bit has been 1 for a run of consecutive frames. It drops the condition only after the bit has been 0 for a run of the same length. A configuration bit sets the run length to 3 or to 5 frames.

Each change of the condition, whether it is raised or dropped, sets a sticky interrupt-status flag. Reading the flag clears it. The interrupt line is this flag gated by an enable bit. Software reaches the block through a small register port. Writes take effect at the clock edge. Reads are combinational from the address, and the clear-on-read takes effect at the edge that ends the read cycle.

The core is a two-state machine. `ALM_IDLE_CLEAR` means no failure is declared; in this state the machine counts consecutive frames that carry a 1. `ALM_RAISED` means the failure is declared; in this state it counts consecutive frames that carry a 0. There are two transitions. `RAISE` goes from `ALM_IDLE_CLEAR` to `ALM_RAISED` when the run of 1s reaches the threshold. `DROP` goes from `ALM_RAISED` to `ALM_IDLE_CLEAR` when the run of 0s reaches the threshold. Both transitions emit a change pulse.

Top module: `frm_alarm_persist`

## Requirements
- R1: After reset the configuration register reads 0. The status bit, the interrupt-status flag and `irq_o` are all 0.
- R2: In the clear state, the condition is declared on the frame that completes N consecutive strobed frames with the alarm bit at 1. N is 3 when the configuration select bit (address 0, bit 0) is 0, and 5 when it is 1. With N-1 such frames the status stays at 0.
- R3: In the declared state, the condition is cleared on the frame that completes N consecutive strobed frames with the alarm bit at 0. N is chosen as in R2.
- R4: A strobed frame whose alarm bit disagrees with the run being counted restarts that run from zero. Cycles without a frame strobe neither count toward a run nor break it.
- R5: A write that changes the select bit resets the run in progress. A frame strobed in the same cycle as that write is not counted.
- R6: Every state change, in either direction, sets the interrupt-status flag. The flag is bit 0 of address 2.
- R7: A read of address 2 returns the flag and clears it at the end of that cycle. If a state change happens in the same cycle, the flag stays set.
- R8: `irq_o` is 1 exactly when the interrupt-status flag is 1 and the interrupt-enable bit (address 0, bit 1) is 1.
- R9: The live status is bit 0 of address 1, and it reads 1 while the condition is declared. Unused bits read 0. Writes to addresses 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld_i | input | 1 | One-cycle strobe marking a received frame |
| frm_alarm_i | input | 1 | Remote-alarm bit of the strobed frame |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, valid in the cycle of the read |
| alarm_o | output | 1 | Live far-end failure status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the boundary between N-1 and N frames in both run lengths. A design with an off-by-one threshold would declare one frame too early or one frame too late. Runs broken by a disagreeing frame, and runs spread out by idle gaps, separate a detector that restarts its count correctly from one that accumulates across the break or resets on idle cycles. A select change in the middle of a run shows whether a stale partial count leaks into the new threshold. A state change that lands in the same cycle as an interrupt-status read shows whether the design loses the event by letting the clear win. Writes to the read-only addresses show whether such writes corrupt the flag or the status.

// File: rtl/frm_alarm_pkg.sv
package frm_alarm_pkg;

    typedef enum logic {
        ALM_IDLE_CLEAR = 1'b0,
        ALM_RAISED     = 1'b1
    } alm_state_e;

    localparam logic [1:0] ADR_CFG  = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_ISR  = 2'd2;

    localparam int CFG_SEL_BIT = 0;
    localparam int CFG_EN_BIT  = 1;

endpackage

// File: rtl/frm_alarm_runctr.sv
module frm_alarm_runctr #(
    parameter int RUN_LONG = 5,
    localparam int CNT_W   = $clog2(RUN_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             at_cap;

    assign at_cap = (cnt_q >= thr_i);
    assign cnt_nx = at_cap ? cnt_q : cnt_q + 1'b1;
    assign hit_o  = inc_i && !restart_i && (cnt_nx >= thr_i);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || hit_o) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_nx;
        end
    end

    // The run count never goes past the longest threshold (R2, R3).
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(RUN_LONG));

    // A restart always leaves the count at zero (R4).
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/frm_alarm_fsm.sv
module frm_alarm_fsm
    import frm_alarm_pkg::*;
#(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 5,
    localparam int CNT_W    = $clog2(RUN_LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_vld_i,
    input  logic frm_alarm_i,
    input  logic sel_long_i,
    input  logic sel_chg_i,
    output logic alarm_o,
    output logic chg_o
);

    alm_state_e       state_q, state_d;
    logic             expect_bit;
    logic             frame_match;
    logic             ctr_restart;
    logic             ctr_inc;
    logic             ctr_hit;
    logic [CNT_W-1:0] ctr_cnt;
    logic [CNT_W-1:0] thr;

    assign thr = sel_long_i ? CNT_W'(RUN_LONG) : CNT_W'(RUN_SHORT);

    always_comb begin
        expect_bit = 1'b1;
        unique case (state_q)
            ALM_IDLE_CLEAR: expect_bit = 1'b1;
            ALM_RAISED:     expect_bit = 1'b0;
            default:        expect_bit = 1'b1;
        endcase
    end

    assign frame_match = (frm_alarm_i == expect_bit);
    assign ctr_restart = sel_chg_i || (frm_vld_i && !frame_match);
    assign ctr_inc     = frm_vld_i && frame_match && !sel_chg_i;

    frm_alarm_runctr #(.RUN_LONG(RUN_LONG)) u_runctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ctr_restart),
        .inc_i     (ctr_inc),
        .thr_i     (thr),
        .hit_o     (ctr_hit),
        .cnt_o     (ctr_cnt)
    );

    // Next state: RAISE and DROP transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE_CLEAR: if (ctr_hit) state_d = ALM_RAISED;
            ALM_RAISED:     if (ctr_hit) state_d = ALM_IDLE_CLEAR;
            default:        state_d = ALM_IDLE_CLEAR;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_IDLE_CLEAR;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        alarm_o = 1'b0;
        chg_o   = 1'b0;
        unique case (state_q)
            ALM_IDLE_CLEAR: begin
                alarm_o = 1'b0;
                chg_o   = (state_d == ALM_RAISED);
            end
            ALM_RAISED: begin
                alarm_o = 1'b1;
                chg_o   = (state_d == ALM_IDLE_CLEAR);
            end
            default: begin
                alarm_o = 1'b0;
                chg_o   = 1'b0;
            end
        endcase
    end

    // The state moves only on a strobed frame (R4).
    assert_no_move_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld_i |=> $stable(alarm_o));

    // Raising needs a frame carrying 1 (R2).
    assert_raise_on_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld_i && !frm_alarm_i) |=> !$rose(alarm_o));

    // Dropping needs a frame carrying 0 (R3).
    assert_drop_on_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld_i && frm_alarm_i) |=> !$fell(alarm_o));

    // A select change cycle never moves the state (R5).
    assert_selchg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg_i |=> $stable(alarm_o));

endmodule

// File: rtl/frm_alarm_regs.sv
module frm_alarm_regs
    import frm_alarm_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              alarm_i,
    input  logic              chg_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              sel_long_o,
    output logic              sel_chg_o,
    output logic              irq_o
);

    logic sel_q;
    logic en_q;
    logic isr_q;
    logic cfg_wr;
    logic isr_rd;

    assign cfg_wr    = wr_i && (addr_i == ADDR_W'(ADR_CFG));
    assign isr_rd    = rd_i && (addr_i == ADDR_W'(ADR_ISR));
    assign sel_chg_o = cfg_wr && (wdata_i[CFG_SEL_BIT] != sel_q);
    assign sel_long_o = sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            en_q  <= 1'b0;
        end else if (cfg_wr) begin
            sel_q <= wdata_i[CFG_SEL_BIT];
            en_q  <= wdata_i[CFG_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      isr_q <= 1'b0;
        else if (chg_i)  isr_q <= 1'b1;
        else if (isr_rd) isr_q <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADR_CFG)) begin
            rdata_o[CFG_SEL_BIT] = sel_q;
            rdata_o[CFG_EN_BIT]  = en_q;
        end else if (addr_i == ADDR_W'(ADR_STAT)) begin
            rdata_o[0] = alarm_i;
        end else if (addr_i == ADDR_W'(ADR_ISR)) begin
            rdata_o[0] = isr_q;
        end
    end

    assign irq_o = isr_q && en_q;

    // A state change always leaves the flag set (R6, R7).
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> isr_q);

    // A read with no new event clears the flag (R7).
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !chg_i) |=> !isr_q);

    // The flag rises only after a change pulse (R6).
    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_i |=> !$rose(isr_q));

endmodule

// File: rtl/frm_alarm_persist.sv
module frm_alarm_persist #(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 5,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld_i,
    input  logic              frm_alarm_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              alarm_o,
    output logic              irq_o
);

    logic sel_long;
    logic sel_chg;
    logic chg;

    frm_alarm_fsm #(
        .RUN_SHORT (RUN_SHORT),
        .RUN_LONG  (RUN_LONG)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_vld_i   (frm_vld_i),
        .frm_alarm_i (frm_alarm_i),
        .sel_long_i  (sel_long),
        .sel_chg_i   (sel_chg),
        .alarm_o     (alarm_o),
        .chg_o       (chg)
    );

    frm_alarm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .wdata_i    (reg_wdata_i),
        .alarm_i    (alarm_o),
        .chg_i      (chg),
        .rdata_o    (reg_rdata_o),
        .sel_long_o (sel_long),
        .sel_chg_o  (sel_chg),
        .irq_o      (irq_o)
    );

    // Every move of the live status is marked by a change pulse (R6).
    assert_status_move_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o != $past(alarm_o)) |-> $past(chg));

endmodule

// File: tb/frm_alarm_persist_bench.sv
module frm_alarm_persist_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_vld_i = 1'b0;
    logic       frm_alarm_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic       reg_wr_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'd0;
    logic [7:0] reg_rdata_o;
    logic       alarm_o;
    logic       irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    frm_alarm_persist u_frm_alarm_persist (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_vld_i   (frm_vld_i),
        .frm_alarm_i (frm_alarm_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_rd_i    (reg_rd_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .alarm_o     (alarm_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic b);
        @(negedge clk);
        frm_vld_i = 1'b1; frm_alarm_i = b;
        @(negedge clk);
        frm_vld_i = 1'b0;
    endtask

    task automatic frames(input logic b, input int n);
        for (int i = 0; i < n; i++) frame(b);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        reg_addr_i = a; reg_rd_i = 1'b1;
        #1 rd_val = reg_rdata_o;
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", {7'd0, alarm_o}, 8'd0);
        chk("R1 irq", {7'd0, irq_o}, 8'd0);
        rd(2'd0); chk("R1 cfg", rd_val, 8'd0);
        rd(2'd2); chk("R1 isr", rd_val, 8'd0);
    endtask

    task automatic t_short_declare;
        wr(2'd0, 8'h02);
        frames(1'b1, 2);
        chk("R2 two ones no declare", {7'd0, alarm_o}, 8'd0);
        chk("R8 irq idle", {7'd0, irq_o}, 8'd0);
        frame(1'b1);
        chk("R2 third one declares", {7'd0, alarm_o}, 8'd1);
        chk("R8 irq raised", {7'd0, irq_o}, 8'd1);
        rd(2'd1); chk("R9 status reg", rd_val, 8'd1);
        rd(2'd2); chk("R6 flag on raise", rd_val, 8'd1);
        rd(2'd2); chk("R7 flag cleared", rd_val, 8'd0);
        chk("R8 irq after clear", {7'd0, irq_o}, 8'd0);
    endtask

    task automatic t_short_clear;
        frames(1'b0, 2);
        chk("R3 two zeros hold", {7'd0, alarm_o}, 8'd1);
        frame(1'b0);
        chk("R3 third zero clears", {7'd0, alarm_o}, 8'd0);
        rd(2'd2); chk("R6 flag on drop", rd_val, 8'd1);
    endtask

    task automatic t_restart;
        frame(1'b1); frame(1'b1); frame(1'b0); frame(1'b1); frame(1'b1);
        chk("R4 broken run no declare", {7'd0, alarm_o}, 8'd0);
        repeat (4) @(negedge clk);
        frame(1'b1);
        chk("R4 gap keeps run", {7'd0, alarm_o}, 8'd1);
        rd(2'd2);
        frame(1'b0); frame(1'b0); frame(1'b1); frame(1'b0); frame(1'b0);
        chk("R4 broken zero run holds", {7'd0, alarm_o}, 8'd1);
        frame(1'b0);
        chk("R4 zero run completes", {7'd0, alarm_o}, 8'd0);
        rd(2'd2);
    endtask

    task automatic t_long;
        wr(2'd0, 8'h03);
        frames(1'b1, 4);
        chk("R2 long four ones hold", {7'd0, alarm_o}, 8'd0);
        frame(1'b1);
        chk("R2 long fifth declares", {7'd0, alarm_o}, 8'd1);
        rd(2'd2);
        frames(1'b0, 4);
        chk("R3 long four zeros hold", {7'd0, alarm_o}, 8'd1);
        frame(1'b0);
        chk("R3 long fifth clears", {7'd0, alarm_o}, 8'd0);
        rd(2'd2);
    endtask

    task automatic t_sel_change;
        wr(2'd0, 8'h02);
        frames(1'b1, 2);
        wr(2'd0, 8'h03);
        frames(1'b1, 3);
        chk("R5 select change resets run", {7'd0, alarm_o}, 8'd0);
        frames(1'b1, 2);
        chk("R5 new length completes", {7'd0, alarm_o}, 8'd1);
        rd(2'd2);
        frames(1'b0, 2);
        @(negedge clk);
        reg_addr_i = 2'd0; reg_wdata_i = 8'h02; reg_wr_i = 1'b1;
        frm_vld_i = 1'b1; frm_alarm_i = 1'b0;
        @(negedge clk);
        reg_wr_i = 1'b0; frm_vld_i = 1'b0;
        frames(1'b0, 2);
        chk("R5 strobe on change not counted", {7'd0, alarm_o}, 8'd1);
        frame(1'b0);
        chk("R5 short run after change", {7'd0, alarm_o}, 8'd0);
        rd(2'd2);
    endtask

    task automatic t_irq_mask;
        wr(2'd0, 8'h00);
        frames(1'b1, 3);
        chk("R8 masked irq", {7'd0, irq_o}, 8'd0);
        wr(2'd0, 8'h02);
        chk("R8 enable shows pending", {7'd0, irq_o}, 8'd1);
        rd(2'd2);
        chk("R8 irq drops on read", {7'd0, irq_o}, 8'd0);
    endtask

    task automatic t_simul_read;
        frames(1'b0, 2);
        @(negedge clk);
        frm_vld_i = 1'b1; frm_alarm_i = 1'b0;
        reg_addr_i = 2'd2; reg_rd_i = 1'b1;
        #1 rd_val = reg_rdata_o;
        @(negedge clk);
        frm_vld_i = 1'b0; reg_rd_i = 1'b0;
        chk("R7 read value before event", rd_val, 8'd0);
        chk("R3 drop with read", {7'd0, alarm_o}, 8'd0);
        rd(2'd2); chk("R7 event not lost", rd_val, 8'd1);
    endtask

    task automatic t_reg_ignore;
        frames(1'b1, 3);
        wr(2'd2, 8'h00);
        rd(2'd2); chk("R9 isr write ignored", rd_val, 8'd1);
        wr(2'd1, 8'h00);
        chk("R9 status write ignored", {7'd0, alarm_o}, 8'd1);
        wr(2'd0, 8'hFE);
        rd(2'd0); chk("R9 cfg unused bits", rd_val, 8'h02);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_short_declare();
                t_short_clear();
                t_restart();
                t_long();
                t_sel_change();
                t_irq_mask();
                t_simul_read();
                t_reg_ignore();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule